// File: doc/BRIEF.md
# Bidirectional Bus Transceiver with Parity Generator and Checker

This block passes an 8-bit word between two buses, A and B, in either direction. It also generates or checks one parity bit on the word. A direction input chooses the flow. When it is high, the A side drives B and the block transmits. When it is low, the B side drives A and the block receives. An active-high disable input releases both data buses and the parity pin together. The data path never inverts a bit.

A single parity pin changes direction with the data. In transmit mode the block drives the pin so that the nine bits (the A word plus parity) hold the parity sense selected by a polarity input: high selects odd, low selects even. In receive mode the pin is an input. The block counts the ones on the B word together with the received parity bit, and an active-low error flag goes low when that total does not match the selected sense.

The block is purely combinational. Each bidirectional pin appears as a separate input, output and output-enable, so the block synthesizes without internal tristate nets. Pad tristate buffers belong outside it.

Top module: `bus_xcvr_parity`

## Requirements
- R1: With `portsOff`=0 and `txDir`=1 (transmit), `bOe`=1, `aOe`=0 and `bOut` equals `aIn` bit for bit.
- R2: With `portsOff`=0 and `txDir`=0 (receive), `aOe`=1, `bOe`=0 and `aOut` equals `bIn` bit for bit.
- R3: With `portsOff`=1, `aOe`, `bOe` and `parOe` are all 0 for either value of `txDir`.
- R4: In transmit with `portsOff`=0, `parOe`=1 and `parOut` is chosen so that the count of ones in `aIn` plus `parOut` is odd when `oddSel`=1 and even when `oddSel`=0.
- R5: In receive with `portsOff`=0, `errN` is 0 exactly when the count of ones in `bIn` plus `parIn` is even with `oddSel`=1, or odd with `oddSel`=0. Otherwise `errN` is 1.
- R6: `errN` is 1 in transmit mode and whenever `portsOff`=1, whatever `parIn` and `bIn` hold.
- R7: `parOe` is 1 only in transmit with `portsOff`=0. In every other case `parIn` has no effect on `aOut`, `bOut` or `parOut`.
- R8: Any data or parity output whose output enable is 0 is driven to all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| txDir | input | 1 | 1 = A drives B (transmit), 0 = B drives A (receive) |
| portsOff | input | 1 | 1 releases both data buses and the parity pin |
| oddSel | input | 1 | 1 selects odd parity, 0 selects even parity |
| aIn | input | 8 | Value sensed on bus A |
| aOut | output | 8 | Value to drive onto bus A |
| aOe | output | 1 | Drive enable for bus A |
| bIn | input | 8 | Value sensed on bus B |
| bOut | output | 8 | Value to drive onto bus B |
| bOe | output | 1 | Drive enable for bus B |
| parIn | input | 1 | Value sensed on the parity pin |
| parOut | output | 1 | Value to drive onto the parity pin |
| parOe | output | 1 | Drive enable for the parity pin |
| errN | output | 1 | Active-low parity error flag for received data |

## Verification
The bench builds the block with its default word width of 8. This makes exhaustive coverage practical: every one of the 256 words is applied under both parity senses, both directions and both disable levels, with a matching and a corrupted parity bit on the pin. Random words then fill the idle bus and the parity pin, to show that the side not selected has no influence. A random phase with a fixed seed mixes all control inputs freely.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Strobes from the direction control to the datapath.
  typedef struct packed {
    logic aDrive;    // datapath sources bus A from bus B
    logic bDrive;    // datapath sources bus B from bus A
    logic parDrive;  // generated parity goes to the parity pin
    logic checkEn;   // received parity is compared and may flag an error
  } xcvrStrobes_t;

endpackage

// File: rtl/xcvr_parity_tree.sv
module xcvr_parity_tree #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dataIn,
  output logic             parityOut   // 1 when dataIn holds an odd number of ones
);

  logic [WIDTH:0] chain;

  assign chain[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_fold
      assign chain[gi+1] = chain[gi] ^ dataIn[gi];
    end
  endgenerate

  assign parityOut = chain[WIDTH];

endmodule

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic         txDir,
  input  logic         portsOff,
  output xcvrStrobes_t strobes
);

  logic portsOn;

  always_comb begin
    portsOn          = ~portsOff;
    strobes.bDrive   = portsOn & txDir;
    strobes.aDrive   = portsOn & ~txDir;
    strobes.parDrive = portsOn & txDir;
    strobes.checkEn  = portsOn & ~txDir;
  end

  // R1 R2: at most one bus is driven at a time
  always_comb begin
    one_driver_chk: assert (!(strobes.aDrive && strobes.bDrive))
      else $error("both buses driven together");
  end

  // R7: the parity pin is never driven while received parity is checked
  always_comb begin
    par_dir_chk: assert (!(strobes.parDrive && strobes.checkEn))
      else $error("parity pin driven while checking");
  end

endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  xcvrStrobes_t      strobes,
  input  logic              oddSel,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic              parIn,
  output logic [DATA_W-1:0] aOut,
  output logic [DATA_W-1:0] bOut,
  output logic              parOut,
  output logic              errN
);

  logic aOddCount;
  logic bOddCount;
  logic parGen;
  logic rxTotalOdd;
  logic rxMismatch;

  xcvr_parity_tree #(.WIDTH(DATA_W)) aTree_i (
    .dataIn    (aIn),
    .parityOut (aOddCount)
  );

  xcvr_parity_tree #(.WIDTH(DATA_W)) bTree_i (
    .dataIn    (bIn),
    .parityOut (bOddCount)
  );

  always_comb begin
    // The generated bit sets the total parity of the 9 bits to oddSel.
    parGen     = aOddCount ^ oddSel;
    rxTotalOdd = bOddCount ^ parIn;
    rxMismatch = rxTotalOdd ^ oddSel;

    bOut   = strobes.bDrive   ? aIn    : '0;
    aOut   = strobes.aDrive   ? bIn    : '0;
    parOut = strobes.parDrive ? parGen : 1'b0;
    errN   = ~(strobes.checkEn & rxMismatch);
  end

  // R4: a driven parity bit always completes the selected sense on A
  always_comb begin
    if (strobes.parDrive) begin
      tx_parity_chk: assert ((aOddCount ^ parOut) == oddSel)
        else $error("generated parity wrong");
    end
  end

endmodule

// File: rtl/bus_xcvr_parity.sv
module bus_xcvr_parity #(
  parameter int DATA_W = 8
) (
  input  logic              txDir,
  input  logic              portsOff,
  input  logic              oddSel,
  input  logic [DATA_W-1:0] aIn,
  output logic [DATA_W-1:0] aOut,
  output logic              aOe,
  input  logic [DATA_W-1:0] bIn,
  output logic [DATA_W-1:0] bOut,
  output logic              bOe,
  input  logic              parIn,
  output logic              parOut,
  output logic              parOe,
  output logic              errN
);

  import xcvr_pkg::*;

  xcvrStrobes_t strobes;

  xcvr_ctrl ctrl_i (
    .txDir    (txDir),
    .portsOff (portsOff),
    .strobes  (strobes)
  );

  xcvr_datapath #(.DATA_W(DATA_W)) dpath_i (
    .strobes (strobes),
    .oddSel  (oddSel),
    .aIn     (aIn),
    .bIn     (bIn),
    .parIn   (parIn),
    .aOut    (aOut),
    .bOut    (bOut),
    .parOut  (parOut),
    .errN    (errN)
  );

  assign aOe   = strobes.aDrive;
  assign bOe   = strobes.bDrive;
  assign parOe = strobes.parDrive;

  // R3
  always_comb begin
    if (portsOff) begin
      all_released_chk: assert (!aOe && !bOe && !parOe)
        else $error("output enabled while ports disabled");
    end
  end

  // R6
  always_comb begin
    if (parOe || portsOff) begin
      err_quiet_chk: assert (errN)
        else $error("error flag low outside receive");
    end
  end

  // R1
  always_comb begin
    if (bOe) begin
      tx_copy_chk: assert (bOut == aIn)
        else $error("B output differs from A input");
    end
  end

  // R2
  always_comb begin
    if (aOe) begin
      rx_copy_chk: assert (aOut == bIn)
        else $error("A output differs from B input");
    end
  end

  // R7
  always_comb begin
    par_oe_follow_chk: assert (!parOe || bOe)
      else $error("parity pin driven without transmit");
  end

endmodule

// File: tb/bus_xcvr_parity_tb.sv
module bus_xcvr_parity_tb_top;

  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic              txDir, portsOff, oddSel, parIn;
  logic [DATA_W-1:0] aIn, bIn;
  logic [DATA_W-1:0] aOut, bOut;
  logic              aOe, bOe, parOut, parOe, errN;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 0;

  bus_xcvr_parity #(.DATA_W(DATA_W)) dut_i (
    .txDir(txDir), .portsOff(portsOff), .oddSel(oddSel),
    .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe),
    .parIn(parIn), .parOut(parOut), .parOe(parOe),
    .errN(errN)
  );

  function automatic int onesOf(input logic [DATA_W-1:0] v);
    int n = 0;
    for (int i = 0; i < DATA_W; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic checkOne(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h (tx=%0b off=%0b odd=%0b a=%0h b=%0h p=%0b)",
               tag, act, exp, txDir, portsOff, oddSel, aIn, bIn, parIn);
    end
  endtask

  task automatic applyAndCheck(input logic t, input logic off, input logic odd,
                               input logic [DATA_W-1:0] av, input logic [DATA_W-1:0] bv,
                               input logic p);
    logic txOn, rxOn, expPar, expErrN;
    int   rxTotal;
    @(posedge clk);
    txDir = t; portsOff = off; oddSel = odd; aIn = av; bIn = bv; parIn = p;
    @(negedge clk);
    txOn   = !off && t;
    rxOn   = !off && !t;
    expPar = ((onesOf(av) % 2) == 1) ^ odd;
    rxTotal = onesOf(bv) + int'(p);
    expErrN = rxOn ? (((rxTotal % 2) == 1) == odd) : 1'b1;
    if (off) begin
      checkOne("R3 aOe", int'(aOe), 0);
      checkOne("R3 bOe", int'(bOe), 0);
      checkOne("R3 parOe", int'(parOe), 0);
    end
    if (txOn) begin
      checkOne("R1 bOe", int'(bOe), 1);
      checkOne("R1 aOe", int'(aOe), 0);
      checkOne("R1 bOut", int'(bOut), int'(av));
      checkOne("R4 parOe", int'(parOe), 1);
      checkOne("R4 parOut", int'(parOut), int'(expPar));
    end
    if (rxOn) begin
      checkOne("R2 aOe", int'(aOe), 1);
      checkOne("R2 bOe", int'(bOe), 0);
      checkOne("R2 aOut", int'(aOut), int'(bv));
      checkOne("R5 errN", int'(errN), int'(expErrN));
      checkOne("R7 parOe", int'(parOe), 0);
    end else begin
      checkOne("R6 errN", int'(errN), 1);
    end
    // R8: released outputs read zero; also shows parIn cannot reach them (R7)
    if (!txOn) begin
      checkOne("R8 bOut", int'(bOut), 0);
      checkOne("R8 parOut", int'(parOut), 0);
    end
    if (!rxOn) checkOne("R8 aOut", int'(aOut), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!doneFlag) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    int seedDummy;
    seedDummy = $urandom(32'h1357);
    txDir = 1'b0; portsOff = 1'b1; oddSel = 1'b0; aIn = '0; bIn = '0; parIn = 1'b0;
    repeat (4) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state: disabled ports, nothing driven, no error (R3, R6)
    checkOne("R3 reset aOe", int'(aOe), 0);
    checkOne("R3 reset bOe", int'(bOe), 0);
    checkOne("R3 reset parOe", int'(parOe), 0);
    checkOne("R6 reset errN", int'(errN), 1);

    // directed corners from the requirements
    applyAndCheck(1'b1, 1'b0, 1'b0, 8'b0001_1111, 8'h00, 1'b0);  // R4 even, five ones -> parity 1
    checkOne("R4 directed even", int'(parOut), 1);
    applyAndCheck(1'b0, 1'b0, 1'b1, 8'hFF, 8'b0000_0111, 1'b1);  // R5 odd, three ones + p=1 -> error
    checkOne("R5 directed odd", int'(errN), 0);
    applyAndCheck(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0);         // R5 all zero, even ok
    applyAndCheck(1'b1, 1'b0, 1'b1, 8'hFF, 8'hFF, 1'b1);         // R4 all ones, odd

    // exhaustive sweep: off x dir x sense x word x parity bit
    for (int off = 0; off < 2; off++)
      for (int t = 0; t < 2; t++)
        for (int odd = 0; odd < 2; odd++)
          for (int d = 0; d < 256; d++)
            for (int p = 0; p < 2; p++) begin
              logic [DATA_W-1:0] other;
              other = DATA_W'($urandom);
              if (t == 1)
                applyAndCheck(1'b1, off[0], odd[0], DATA_W'(d), other, p[0]);
              else
                applyAndCheck(1'b0, off[0], odd[0], other, DATA_W'(d), p[0]);
            end

    // free random mix
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] r;
      r = $urandom;
      applyAndCheck(r[0], r[1] & r[2], r[3], DATA_W'($urandom), DATA_W'($urandom), r[4]);
    end

    doneFlag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule